// File: doc/BRIEF.md
# Remainder-Carrying Single-Pole Smoothing Filter

This block is a first-order low-pass smoother for a stream of signed integer samples. Each accepted sample moves the filtered value toward the input by one power-of-two fraction of the gap between them. The division is integer arithmetic, but the part that the shift drops is not lost. It is kept in a small register and added to the gap on the next sample.

A plain truncating filter of this kind can settle at a value a few steps away from a constant input and stay there for ever. Because the dropped fraction is carried forward here, it always builds up into a whole step, so the output reaches a held input exactly. The filter suits narrow data paths: the default build uses 8-bit samples and a fixed shift chosen at compile time.

A sample is accepted on any clock edge where the valid input is high. The filtered value and a one-cycle valid strobe come out on the following cycle. When the valid input is low, the filter holds its state.

Top module: `iir_remainder_smoother`

## Requirements
- R1: After a synchronous active-high reset, the filtered output is 0, the output strobe is low, and the carried remainder is 0. As a result, the first sample x after reset produces floor(x / 2^GAIN_SHIFT).
- R2: The output strobe is high in the cycle after each clock edge on which the valid input was high, and low in the cycle after each edge on which it was low.
- R3: For each accepted sample x, with held output y and carried remainder r, the filter forms e = x - y + r. The new output is y + floor(e / 2^GAIN_SHIFT), and the new remainder is e mod 2^GAIN_SHIFT, which always lies in 0 .. 2^GAIN_SHIFT-1. Both use floor semantics, including for negative e.
- R4: On edges where the valid input is low, neither the output nor the carried remainder changes. The next accepted sample therefore gives the same result as if the idle cycles had not occurred.
- R5: When a constant input is held, the output becomes exactly equal to that input within 40 * 2^GAIN_SHIFT accepted samples, with no residual offset.
- R6: Each new output lies between the previous output and the accepted input, inclusive, so the output never overshoots and never wraps at SAMPLE_W bits.
- R7: An accepted sample equal to the current output leaves the output unchanged, whatever the carried remainder is.
- R8: The sample width SAMPLE_W and the shift GAIN_SHIFT (GAIN_SHIFT of at least 1) are parameters. The internal error term is SAMPLE_W+2 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Accept inSample on this edge |
| inSample | input | SAMPLE_W | Signed input sample |
| outSample | output | SAMPLE_W | Signed filtered value |
| outValid | output | 1 | High for one cycle after each accepted sample |

## Verification
The bench builds the filter with SAMPLE_W = 8 and GAIN_SHIFT = 3, which gives a division by 8. With these values, full-scale steps between -128 and 127 can be driven, and the error term approaches the edges of its range. The shift is also large enough that the remainder takes seven nonzero values. That gives the carry path real work to do, and a plain truncating filter would stall a visible distance from the target. The chosen values also let steps, ramps and idle gaps be checked bit-exactly against a model written from the update formula. They bring the settle bound within a few hundred samples.

// File: rtl/iir_rc_pkg.sv
package iir_rc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // accept the present sample
    logic clear;  // return state to zero
  } ctlStrobe_t;

endpackage

// File: rtl/iir_rc_control.sv
module iir_rc_control
  import iir_rc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output ctlStrobe_t ctl,
  output logic       outValid
);

  always_comb begin
    ctl.clear = rst;
    ctl.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R2: strobe follows an accepted sample by one cycle
  assert_valid_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R2: no strobe after an idle edge
  assert_quiet_after_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/iir_rc_datapath.sv
module iir_rc_datapath
  import iir_rc_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int GAIN_SHIFT = 3
) (
  input  logic                       clk,
  input  ctlStrobe_t                 ctl,
  input  logic signed [SAMPLE_W-1:0] inSample,
  output logic signed [SAMPLE_W-1:0] yOut
);

  localparam int ERR_W = SAMPLE_W + 2;
  localparam int REM_W = GAIN_SHIFT;

  logic signed [SAMPLE_W-1:0] yQ;
  logic        [REM_W-1:0]    remQ;
  logic signed [ERR_W-1:0]    xWide;
  logic signed [ERR_W-1:0]    yWide;
  logic signed [ERR_W-1:0]    remWide;
  logic signed [ERR_W-1:0]    errTerm;
  logic signed [ERR_W-1:0]    quot;
  logic signed [SAMPLE_W-1:0] yNext;
  logic        [REM_W-1:0]    remNext;

  always_comb begin
    xWide   = {{2{inSample[SAMPLE_W-1]}}, inSample};
    yWide   = {{2{yQ[SAMPLE_W-1]}}, yQ};
    remWide = $signed({{(ERR_W-REM_W){1'b0}}, remQ});
    errTerm = xWide - yWide + remWide;
    quot    = errTerm >>> GAIN_SHIFT;          // floor division by 2^GAIN_SHIFT
    remNext = errTerm[REM_W-1:0];              // floor modulo
    yNext   = yQ + quot[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      yQ   <= '0;
      remQ <= '0;
    end else if (ctl.load) begin
      yQ   <= yNext;
      remQ <= remNext;
    end
  end

  assign yOut = yQ;

  // R4: idle edges leave state alone
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (ctl.clear)
    !ctl.load |=> ($stable(yQ) && $stable(remQ)));

  // R7: input equal to output is a fixed point
  assert_fixed_point_R7: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.load && inSample == yQ) |=> $stable(yQ));

  // R6: rising toward input never passes it
  assert_no_overshoot_up_R6: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.load && inSample >= yQ) |=> (yQ >= $past(yQ) && yQ <= $past(inSample)));

  // R6: falling toward input never passes it
  assert_no_overshoot_down_R6: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.load && inSample < yQ) |=> (yQ <= $past(yQ) && yQ >= $past(inSample)));

endmodule

// File: rtl/iir_remainder_smoother.sv
module iir_remainder_smoother
  import iir_rc_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int GAIN_SHIFT = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inSample,
  output logic signed [SAMPLE_W-1:0] outSample,
  output logic                       outValid
);

  ctlStrobe_t ctl;

  iir_rc_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  iir_rc_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .GAIN_SHIFT (GAIN_SHIFT)
  ) u_dp (
    .clk      (clk),
    .ctl      (ctl),
    .inSample (inSample),
    .yOut     (outSample)
  );

endmodule

// File: tb/iir_remainder_smoother_tb.sv
module iir_remainder_smoother_tb_top;

  localparam int SAMPLE_W   = 8;
  localparam int GAIN_SHIFT = 3;
  localparam int DIV        = 1 << GAIN_SHIFT;
  localparam int SETTLE     = 40 * DIV;

  typedef struct {
    int expY;
    int x;
    int prevY;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [SAMPLE_W-1:0] inSample = '0;
  logic signed [SAMPLE_W-1:0] outSample;
  logic outValid;

  int nChecks = 0;
  int nErrors = 0;
  item_t sb[$];
  int mY = 0;
  int mR = 0;

  always #2 clk = ~clk;

  iir_remainder_smoother #(.SAMPLE_W(SAMPLE_W), .GAIN_SHIFT(GAIN_SHIFT)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outSample(outSample), .outValid(outValid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: applies a sample and pushes the expected result
  task automatic sendSample(input int x);
    int e, m, q;
    item_t it;
    @(negedge clk);
    inValid  = 1'b1;
    inSample = x[SAMPLE_W-1:0];
    e = x - mY + mR;
    m = ((e % DIV) + DIV) % DIV;
    q = (e - m) / DIV;
    it.prevY = mY;
    it.x     = x;
    mR = m;
    mY = mY + q;
    it.expY  = mY;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    mY = 0;
    mR = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: pops and compares as results appear
  int lastY = 0;
  initial begin
    forever begin
      bit wasValid, wasRst;
      item_t it;
      @(posedge clk);
      wasValid = inValid;
      wasRst   = rst;
      #1;
      if (wasRst) begin
        lastY = 0;
      end else begin
        chk(outValid == wasValid, "R2 strobe", int'(outValid), int'(wasValid));
        if (outValid) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R2 unexpected strobe", 1, 0);
          end else begin
            it = sb.pop_front();
            chk(int'(outSample) == it.expY, "R3 update", int'(outSample), it.expY);
            if (it.x >= it.prevY)
              chk(int'(outSample) >= it.prevY && int'(outSample) <= it.x,
                  "R6 bounded rise", int'(outSample), it.x);
            else
              chk(int'(outSample) <= it.prevY && int'(outSample) >= it.x,
                  "R6 bounded fall", int'(outSample), it.x);
            lastY = it.expY;
          end
        end else begin
          chk(int'(outSample) == lastY, "R4 hold while idle", int'(outSample), lastY);
        end
      end
    end
  end

  task automatic holdConst(input int x, input int gap, input string tag);
    for (int i = 0; i < SETTLE; i++) begin
      sendSample(x);
      if (gap > 0) idle(gap);
    end
    drain();
    chk(int'(outSample) == x, tag, int'(outSample), x);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(int'(outSample) == 0, "R1 output after reset", int'(outSample), 0);
    chk(outValid == 1'b0, "R1 strobe after reset", int'(outValid), 0);

    // R1/R3: first sample from cleared state, remainder starts at 0
    sendSample(100);
    drain();
    chk(int'(outSample) == 12, "R1 first sample 100", int'(outSample), 12);

    // R5: full-scale step up
    holdConst(127, 0, "R5 settle to 127");
    // R7: equal input does not move output
    sendSample(127); idle(2); sendSample(127);
    drain();
    chk(int'(outSample) == 127, "R7 fixed point 127", int'(outSample), 127);

    // R3: negative first sample uses floor division
    doReset();
    sendSample(-100);
    drain();
    chk(int'(outSample) == -13, "R3 floor of -100/8", int'(outSample), -13);

    // R5: full-scale negative
    holdConst(-128, 0, "R5 settle to -128");

    // R4 + R5: step with idle gaps between samples
    holdConst(5, 3, "R5 settle to 5 with gaps");

    // R5: small negative target, where truncation would stall
    holdConst(-3, 1, "R5 settle to -3");
    sendSample(-3);
    drain();
    chk(int'(outSample) == -3, "R7 fixed point -3", int'(outSample), -3);

    // R3/R6: ramps
    for (int v = -120; v <= 120; v += 3) sendSample(v);
    for (int v = 120; v >= -120; v -= 7) begin sendSample(v); idle(1); end
    drain();

    // R8: small positive target reached exactly at this width and shift
    holdConst(1, 0, "R8 settle to 1");

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule